// File: doc/BRIEF.md
# ADC Acquisition Controller

This block is the register front end that runs conversions on an external 12-bit analog-to-digital converter. Software uses a byte-wide bus to select the input channel and the amplifier gain, and to pick an operating mode. Each mode names one trigger source and one way to hand over the result. A conversion can start from a write to the software trigger address, from a tick of an external pacer timer, or from a rising edge on an external trigger pin. The block sends a one-cycle start pulse to the converter. When the converter reports completion, the block stores the result.

The 12-bit result is read as two bytes. The byte that holds the upper four result bits also carries an active-low ready flag. Reading the lower byte sets that flag high again. In the interrupt modes, each finished conversion sets a status flag. The flag drives exactly one line of an 8-bit interrupt vector, chosen by a line code, and stays set until software writes to the clear address. The multiplexer, the amplifier, the converter and the pacer timer are outside the block and appear only as ports.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, conv start is low, the interrupt vector is zero, the channel and gain outputs are 0, and offset 5 reads 0x10 (ready flag high, meaning no result).
- R2: In software mode, a write of any data to offset 12 gives exactly one start pulse, one cycle wide.
- R3: In the external modes, a rising edge on the trigger pin gives one start pulse. Holding the pin high gives no further pulses.
- R4: The offset 11 register holds the mode code in bits 2..0. The codes are: 000 software/polled, 001 external/polled, 010 external/interrupt, 100 pacer/polled, 110 pacer/interrupt. The reserved codes 011, 101 and 111 behave as 000. A trigger source that the mode does not select produces no start pulse.
- R5: A trigger that arrives while a conversion is busy (after its start and before its done) is dropped. After done, the next trigger is accepted.
- R6: Offset 4 reads result bits 7..0. Offset 5 reads result bits 11..8 in bits 3..0, the ready flag in bit 4, and zeros in bits 7..5.
- R7: The ready flag (offset 5 bit 4) goes to 0 on converter done and to 1 on a start pulse or a read of offset 4. Reading offset 5 does not change it. If done and an offset 4 read fall in the same cycle, the flag goes to 0.
- R8: In the interrupt modes, a completed conversion sets the status flag. The flag drives interrupt vector bit N for line code N, where N is 2..7 and the code sits in bits 6..4 of offset 11. Codes 0 and 1 drive no line. The polled modes never raise the vector.
- R9: A write of any data to offset 8 clears the status flag. If a completion falls in the same cycle as the clear, the flag stays set.
- R10: The channel output follows bits 2..0 of the last write to offset 10. The gain output follows bits 2..0 of offset 9, but codes above 4 are output as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| pacer_tick | input | 1 | One-cycle tick from the pacer timer |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | One-cycle conversion complete |
| adc_data | input | 12 | Result, valid with adc_done |
| mux_chan | output | 3 | Selected input channel |
| pga_gain | output | 3 | Gain code, saturated at 4 |
| irq_out | output | 8 | One-hot interrupt vector |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a converter completion and the status clear write to offset 8. The second pair is a completion and the low-byte read that re-arms the ready flag. The bench turns off its automatic converter model so it can drive adc_done by hand on the same clock edge as the bus strobe. It then judges the result at the ports. In the first case, the selected interrupt line must still be high. In the second case, offset 5 must still show the ready flag low, together with the new upper bits.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  typedef enum logic [1:0] {SRC_SW, SRC_EXT, SRC_PACER} trig_src_e;

  localparam logic [3:0] OFS_RES_LO = 4'd4;
  localparam logic [3:0] OFS_RES_HI = 4'd5;
  localparam logic [3:0] OFS_CLR    = 4'd8;
  localparam logic [3:0] OFS_GAIN   = 4'd9;
  localparam logic [3:0] OFS_CHAN   = 4'd10;
  localparam logic [3:0] OFS_MODE   = 4'd11;
  localparam logic [3:0] OFS_SWTRIG = 4'd12;

  localparam int READY_BIT = 4;
endpackage

// File: rtl/acq_regs.sv
module acq_regs
  import adc_acq_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int CODE_W   = 3,
  parameter int GAIN_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CODE_W-1:0] chan_o,
  output logic [CODE_W-1:0] gain_o,
  output trig_src_e         src_o,
  output logic              int_en_o,
  output logic [CODE_W-1:0] irq_code_o,
  output logic              sw_hit_o,
  output logic              clr_hit_o,
  output logic              rd_lo_o
);
  localparam int IRQ_LSB = 4;

  logic [CODE_W-1:0] chan_q, chan_d, gain_q, gain_d, mode_q, mode_d, irq_q, irq_d;
  logic              unused_bits;

  assign unused_bits = ^{wdata[BUS_W-1], wdata[IRQ_LSB-1]};

  always_comb begin
    chan_d = chan_q;
    gain_d = gain_q;
    mode_d = mode_q;
    irq_d  = irq_q;
    if (wr_en) begin
      case (addr)
        OFS_CHAN: chan_d = wdata[CODE_W-1:0];
        OFS_GAIN: gain_d = wdata[CODE_W-1:0];
        OFS_MODE: begin
          mode_d = wdata[CODE_W-1:0];
          irq_d  = wdata[IRQ_LSB+CODE_W-1:IRQ_LSB];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      gain_q <= '0;
      mode_q <= '0;
      irq_q  <= '0;
    end else if (wr_en) begin
      chan_q <= chan_d;
      gain_q <= gain_d;
      mode_q <= mode_d;
      irq_q  <= irq_d;
    end
  end

  // Mode decode: reserved codes fall back to software/polled
  always_comb begin
    src_o    = SRC_SW;
    int_en_o = 1'b0;
    case (mode_q)
      3'b001:  src_o = SRC_EXT;
      3'b010:  begin src_o = SRC_EXT;   int_en_o = 1'b1; end
      3'b100:  src_o = SRC_PACER;
      3'b110:  begin src_o = SRC_PACER; int_en_o = 1'b1; end
      default: ;
    endcase
  end

  assign chan_o     = chan_q;
  assign gain_o     = (gain_q > CODE_W'(GAIN_MAX)) ? CODE_W'(GAIN_MAX) : gain_q;
  assign irq_code_o = irq_q;
  assign sw_hit_o   = wr_en && (addr == OFS_SWTRIG);
  assign clr_hit_o  = wr_en && (addr == OFS_CLR);
  assign rd_lo_o    = rd_en && (addr == OFS_RES_LO);

  p_gain_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gain_o <= CODE_W'(GAIN_MAX));
endmodule

// File: rtl/acq_trig.sv
module acq_trig
  import adc_acq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      sw_hit,
  input  logic      pacer_tick,
  input  logic      ext_pin,
  input  logic      conv_done,
  output logic      conv_start,
  output logic      busy
);
  logic [SYNC_STAGES:0] ext_sh_q;
  logic                 ext_rise, trig_sel, start_d, busy_d, start_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh_q <= '0;
    else        ext_sh_q <= {ext_sh_q[SYNC_STAGES-1:0], ext_pin};
  end

  assign ext_rise = ext_sh_q[SYNC_STAGES-1] & ~ext_sh_q[SYNC_STAGES];

  always_comb begin
    case (src)
      SRC_EXT:   trig_sel = ext_rise;
      SRC_PACER: trig_sel = pacer_tick;
      default:   trig_sel = sw_hit;
    endcase
    start_d = trig_sel && !busy_q;
    busy_d  = busy_q;
    if (start_d)        busy_d = 1'b1;
    else if (conv_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      busy_q  <= busy_d;
    end
  end

  assign conv_start = start_q;
  assign busy       = busy_q;

  p_one_cycle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_drop_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> !start_q);
endmodule

// File: rtl/acq_result.sv
module acq_result
  import adc_acq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic                  conv_start,
  input  logic                  rd_lo,
  input  logic                  clr_hit,
  input  logic                  int_en,
  input  logic [CODE_W-1:0]     irq_code,
  input  logic [3:0]            addr,
  output logic [BUS_W-1:0]      rdata,
  output logic [2**CODE_W-1:0]  irq_vec
);
  localparam int HI_W    = DATA_W - BUS_W;
  localparam int MIN_IRQ = 2;

  logic [DATA_W-1:0] res_q;
  logic              ready_n_q, ready_n_d, flag_q, flag_d;
  logic [BUS_W-1:0]  hi_byte;

  always_comb begin
    ready_n_d = ready_n_q;
    if (conv_done)                 ready_n_d = 1'b0;
    else if (conv_start || rd_lo)  ready_n_d = 1'b1;
    flag_d = flag_q;
    if (conv_done && int_en)       flag_d = 1'b1;
    else if (clr_hit)              flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (conv_done) res_q <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_n_q <= 1'b1;
      flag_q    <= 1'b0;
    end else begin
      ready_n_q <= ready_n_d;
      flag_q    <= flag_d;
    end
  end

  always_comb begin
    hi_byte            = '0;
    hi_byte[HI_W-1:0]  = res_q[DATA_W-1:BUS_W];
    hi_byte[READY_BIT] = ready_n_q;
    case (addr)
      OFS_RES_LO: rdata = res_q[BUS_W-1:0];
      OFS_RES_HI: rdata = hi_byte;
      default:    rdata = '0;
    endcase
  end

  always_comb begin
    irq_vec = '0;
    if (flag_q && irq_code >= CODE_W'(MIN_IRQ)) irq_vec[irq_code] = 1'b1;
  end

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !ready_n_q);
  p_int_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && int_en) |=> flag_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !conv_done) |=> !flag_q);
  p_irq_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_vec));
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BUS_W       = 8,
  parameter int CODE_W      = 3,
  parameter int GAIN_MAX    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [3:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 pacer_tick,
  input  logic                 ext_trig,
  output logic                 adc_start,
  input  logic                 adc_done,
  input  logic [DATA_W-1:0]    adc_data,
  output logic [CODE_W-1:0]    mux_chan,
  output logic [CODE_W-1:0]    pga_gain,
  output logic [2**CODE_W-1:0] irq_out
);
  logic [RST_STAGES-1:0] rst_sh_q;
  logic                  rst_n_i;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_i = rst_sh_q[RST_STAGES-1];

  trig_src_e         src;
  logic              int_en, sw_hit, clr_hit, rd_lo, busy;
  logic [CODE_W-1:0] irq_code;

  acq_regs #(.BUS_W(BUS_W), .CODE_W(CODE_W), .GAIN_MAX(GAIN_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .chan_o(mux_chan), .gain_o(pga_gain),
    .src_o(src), .int_en_o(int_en), .irq_code_o(irq_code),
    .sw_hit_o(sw_hit), .clr_hit_o(clr_hit), .rd_lo_o(rd_lo)
  );

  acq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n_i), .src(src), .sw_hit(sw_hit),
    .pacer_tick(pacer_tick), .ext_pin(ext_trig), .conv_done(adc_done),
    .conv_start(adc_start), .busy(busy)
  );

  acq_result #(.DATA_W(DATA_W), .BUS_W(BUS_W), .CODE_W(CODE_W)) u_res (
    .clk(clk), .rst_n(rst_n_i), .conv_done(adc_done), .conv_data(adc_data),
    .conv_start(adc_start), .rd_lo(rd_lo), .clr_hit(clr_hit),
    .int_en(int_en), .irq_code(irq_code), .addr(bus_addr),
    .rdata(bus_rdata), .irq_vec(irq_out)
  );

  p_busy_has_start_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(busy) |-> adc_start);
endmodule

// File: tb/tb_adc_acq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_acq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        pacer_tick = 1'b0, ext_trig = 1'b0;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [2:0]  mux_chan, pga_gain;
  logic [7:0]  irq_out;

  int errors = 0, checks = 0, starts = 0;
  bit auto_conv = 1'b1;
  bit finished = 1'b0;
  logic [11:0] cur_val = '0;

  always #2.5 clk = ~clk;

  adc_acq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .mux_chan(mux_chan),
    .pga_gain(pga_gain), .irq_out(irq_out)
  );

  always @(negedge clk) if (adc_start) starts++;

  // Converter model: done three cycles after start
  initial forever begin
    @(negedge clk);
    if (auto_conv && adc_start) begin
      repeat (3) @(negedge clk);
      adc_done = 1'b1;
      adc_data = cur_val;
      @(negedge clk);
      adc_done = 1'b0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_mode(logic [2:0] m, logic [2:0] irq);
    bus_write(4'd11, {1'b0, irq, 1'b0, m});
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  task automatic ext_edge();
    @(negedge clk); ext_trig = 1'b1;
    wait_cyc(12);
    ext_trig = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int s0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    bus_read(4'd5, rd);
    check("R1 hi byte", rd, 8'h10);
    check("R1 irq", irq_out, 0);
    check("R1 start", adc_start, 0);
    check("R1 chan", mux_chan, 0);
    check("R1 gain", pga_gain, 0);

    // R10 channel and gain sweep
    for (int c = 0; c < 8; c++) begin
      bus_write(4'd10, 8'hF8 | c[7:0]);
      bus_write(4'd9, c[7:0]);
      check("R10 chan", mux_chan, c);
      check("R10 gain", pga_gain, (c > 4) ? 4 : c);
    end

    // R2 R6 R7 software trigger and result split over value sweep
    set_mode(3'b000, 3'd0);
    for (int i = 0; i < 16; i++) begin
      cur_val = 12'((i * 273) ^ (i << 7));
      s0 = starts;
      bus_write(4'd12, 8'(i * 37));
      wait_cyc(8);
      check("R2 one start", starts - s0, 1);
      bus_read(4'd5, rd);
      check("R6 R7 hi ready", rd, {3'b000, 1'b0, cur_val[11:8]});
      bus_read(4'd5, rd);
      check("R7 hi read keeps flag", rd, {3'b000, 1'b0, cur_val[11:8]});
      bus_read(4'd4, rd);
      check("R6 lo byte", rd, cur_val[7:0]);
      bus_read(4'd5, rd);
      check("R7 rearm", rd, {3'b000, 1'b1, cur_val[11:8]});
      check("R8 polled no irq", irq_out, 0);
    end

    // R4 non-selected sources ignored in software mode
    s0 = starts;
    pulse_pacer();
    ext_edge();
    check("R4 sw mode ignores pacer/ext", starts - s0, 0);

    // R3 external mode
    set_mode(3'b001, 3'd0);
    s0 = starts;
    ext_edge();
    check("R3 ext edge", starts - s0, 1);
    s0 = starts;
    @(negedge clk); ext_trig = 1'b1;
    wait_cyc(12);
    check("R3 ext edge once", starts - s0, 1);
    s0 = starts;
    wait_cyc(12);
    check("R3 level no retrigger", starts - s0, 0);
    ext_trig = 1'b0; wait_cyc(4);
    s0 = starts;
    bus_write(4'd12, 8'h00);
    pulse_pacer();
    wait_cyc(8);
    check("R4 ext mode ignores sw/pacer", starts - s0, 0);

    // R4 pacer mode
    set_mode(3'b100, 3'd0);
    s0 = starts;
    pulse_pacer();
    wait_cyc(8);
    check("R4 pacer tick", starts - s0, 1);
    s0 = starts;
    bus_write(4'd12, 8'h55);
    ext_edge();
    check("R4 pacer mode ignores sw/ext", starts - s0, 0);

    // R4 reserved codes behave as software mode
    for (int m = 3; m < 8; m += 2) begin
      set_mode(3'(m), 3'd0);
      s0 = starts;
      pulse_pacer();
      wait_cyc(8);
      bus_write(4'd12, 8'hFF);
      wait_cyc(8);
      check("R4 reserved as sw", starts - s0, 1);
    end

    // R8 R9 interrupt lines in external/interrupt mode
    for (int q = 0; q < 8; q++) begin
      set_mode(3'b010, 3'(q));
      ext_edge();
      check("R8 irq line", irq_out, (q >= 2) ? (1 << q) : 0);
      bus_write(4'd8, 8'hA5);
      check("R9 clear", irq_out, 0);
    end
    set_mode(3'b110, 3'd7);
    pulse_pacer();
    wait_cyc(8);
    check("R8 pacer int", irq_out, 8'h80);
    bus_write(4'd8, 8'h00);
    check("R9 clear pacer", irq_out, 0);

    // R5 busy drop
    auto_conv = 1'b0;
    set_mode(3'b000, 3'd0);
    s0 = starts;
    bus_write(4'd12, 8'h01);
    wait_cyc(4);
    bus_write(4'd12, 8'h02);
    wait_cyc(4);
    check("R5 dropped while busy", starts - s0, 1);
    @(negedge clk); adc_done = 1'b1; adc_data = 12'h123;
    @(negedge clk); adc_done = 1'b0;
    s0 = starts;
    bus_write(4'd12, 8'h03);
    wait_cyc(4);
    check("R5 accepted after done", starts - s0, 1);

    // R7 done and low-byte read in the same cycle
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'd4; adc_done = 1'b1; adc_data = 12'hABC;
    @(negedge clk);
    bus_rd = 1'b0; adc_done = 1'b0;
    bus_read(4'd5, rd);
    check("R7 done beats read", rd, 8'h0A);
    bus_read(4'd4, rd);
    check("R6 lo after collision", rd, 8'hBC);

    // R9 done and clear in the same cycle
    set_mode(3'b010, 3'd5);
    s0 = starts;
    ext_edge();
    check("R3 int ext start", starts - s0, 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd8; adc_done = 1'b1; adc_data = 12'h5A5;
    @(negedge clk);
    bus_wr = 1'b0; adc_done = 1'b0;
    check("R9 set beats clear", irq_out, 8'h20);
    bus_write(4'd8, 8'h00);
    check("R9 clear after collision", irq_out, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule